// File: doc/BRIEF.md
# Control-Track Pulse Duty Classifier and Record Pulse Generator

This block handles the control-track pulse stream of a tape transport. In detect mode it times every incoming playback pulse in clock cycles. It takes the length of the high phase and the full period from one rising edge to the next. It then decides whether the high phase covers at least 44 % of the period, and checks this with an exact integer comparison (high × 100 against period × 44) rather than a division. The verdict goes into a duty flag, and a sticky interrupt is raised once per completed pulse.

In record mode the block drives an outgoing control pulse train on its own. The period and high-phase lengths come from one of two programmable register pairs. The pair is chosen by the value software last wrote into the same duty flag bit. New lengths and a new pair choice are taken only at a period boundary, so the output never carries a shortened or stretched pulse. A small register port gives access to the mode field, the flag/interrupt status and the four length registers.

Top module: `ctl_duty_unit`

## Requirements
- R1: After reset the mode field (address 0, bits 4:0) reads 0, which is detect mode, the status register (address 1) reads 0, the interrupt output is low and the record output is low.
- R2: In detect mode a completed pulse whose high time H and period P (both in clock cycles) satisfy H×100 ≥ P×44 sets the duty flag (address 1, bit 0) to 1, and this includes the exact 44 % case.
- R3: In detect mode a completed pulse with H×100 < P×44 clears the duty flag to 0.
- R4: Each completed pulse in detect mode sets the interrupt flag (address 1, bit 1, also driven on `irq`). The flag stays set until software writes 1 to bit 1 of address 1. The first rising edge after reset or after an operating-mode change only arms the timer and raises no interrupt.
- R5: In record mode (mode field bits {4,1,0} = 001) with duty flag 0, the record output repeats a pulse that is high for the count in address 3 and lasts the count in address 2.
- R6: In record mode with duty flag 1, the pulse uses the high count in address 5 and the period in address 4.
- R7: A change to the length registers or to the duty flag in record mode leaves the period in progress unchanged and takes effect from the next period boundary.
- R8: Mode bits 3 and 2 read back 0 one clock after a write of 1 to them, and they do not change the operating mode.
- R9: Mode field values whose bits {4,1,0} are neither 000 nor 001 select idle mode. In idle mode the record output stays low, pulses raise no interrupt and the duty flag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_pb_in | input | 1 | Playback control pulse input (asynchronous, synchronized inside) |
| ctl_rec_out | output | 1 | Generated record control pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 mode, 1 status, 2/3 period/high pair A, 4/5 period/high pair B |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Sticky interrupt request, one event per completed detected pulse |

## Verification
A wrong edge counter or a lost arming state in the detector shows up as a wrong duty flag value or a wrong interrupt. This is visible on the status register a few cycles after the rising edge that completes a pulse, which is two synchronizer stages plus one register stage later. The bench uses ratios exactly at 44 % and one count below it, so an off-by-one in either count flips the verdict. In record mode a broken period counter or an early load of the shadow lengths changes the high and period lengths of the very next pulse, and the bench times these at the output pin. Strobe bits that fail to self-clear read back wrong after a single clock.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  typedef enum logic [1:0] {
    OP_DETECT = 2'd0,
    OP_RECORD = 2'd1,
    OP_IDLE   = 2'd2
  } ctl_op_e;

  localparam int unsigned ADDR_MODE  = 0;
  localparam int unsigned ADDR_STAT  = 1;
  localparam int unsigned ADDR_PER_A = 2;
  localparam int unsigned ADDR_HI_A  = 3;
  localparam int unsigned ADDR_PER_B = 4;
  localparam int unsigned ADDR_HI_B  = 5;

  localparam int unsigned LEN_REGS   = 4;

  // operating mode from the persistent mode bits; bits 3:2 are strobes only
  function automatic ctl_op_e decode_op(input logic [4:0] mode);
    case ({mode[4], mode[1:0]})
      3'b000:  decode_op = OP_DETECT;
      3'b001:  decode_op = OP_RECORD;
      default: decode_op = OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/ctl_in_sync.sv
module ctl_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] sh_q, sh_d;
  logic            level, prev;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[STAGES-1];
  assign prev  = sh_q[STAGES];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

endmodule

// File: rtl/ctl_duty_meter.sv
module ctl_duty_meter #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned DUTY_PCT = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic rise,
  input  logic fall,
  output logic meas_valid,
  output logic meas_ge
);

  localparam int unsigned PW = CNT_W + 7;

  logic [CNT_W-1:0] run_q, run_d, high_q, high_d;
  logic             armed_q, armed_d, fell_q, fell_d, sat_q, sat_d;
  logic [PW-1:0]    hi_scaled, per_scaled;

  assign hi_scaled  = PW'(high_q) * PW'(100);
  assign per_scaled = PW'(run_q) * PW'(DUTY_PCT);
  assign meas_ge    = hi_scaled >= per_scaled;

  always_comb begin
    run_d      = run_q;
    high_d     = high_q;
    armed_d    = armed_q;
    fell_d     = fell_q;
    sat_d      = sat_q;
    meas_valid = 1'b0;
    if (!en || restart) begin
      run_d   = '0;
      armed_d = 1'b0;
      fell_d  = 1'b0;
      sat_d   = 1'b0;
    end else if (rise) begin
      // run_q holds the full period here, high_q the high phase of it
      meas_valid = armed_q & fell_q & ~sat_q;
      armed_d    = 1'b1;
      fell_d     = 1'b0;
      sat_d      = 1'b0;
      run_d      = CNT_W'(1);
    end else begin
      if (run_q == '1) sat_d = 1'b1;
      else             run_d = run_q + CNT_W'(1);
      if (fall && armed_q) begin
        high_d = run_q;
        fell_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      high_q  <= '0;
      armed_q <= 1'b0;
      fell_q  <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      high_q  <= high_d;
      armed_q <= armed_d;
      fell_q  <= fell_d;
      sat_q   <= sat_d;
    end
  end

endmodule

// File: rtl/ctl_rec_gen.sv
module ctl_rec_gen #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             sel_b,
  input  logic [CNT_W-1:0] per_a,
  input  logic [CNT_W-1:0] high_a,
  input  logic [CNT_W-1:0] per_b,
  input  logic [CNT_W-1:0] high_b,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d, act_per_q, act_per_d, act_high_q, act_high_d;
  logic             out_q, out_d, boundary;

  assign boundary = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, act_per_q};

  always_comb begin
    cnt_d      = cnt_q;
    act_per_d  = act_per_q;
    act_high_d = act_high_q;
    if (!en) begin
      cnt_d = '0;
    end else if (restart || boundary) begin
      // shadow load only here, so a running period is never reshaped
      cnt_d      = '0;
      act_per_d  = sel_b ? per_b  : per_a;
      act_high_d = sel_b ? high_b : high_a;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    out_d = en && (cnt_d < act_high_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_per_q  <= '0;
      act_high_q <= '0;
      out_q      <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      act_per_q  <= act_per_d;
      act_high_q <= act_high_d;
      out_q      <= out_d;
    end
  end

  assign pulse = out_q;

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import ctl_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             meas_valid,
  input  logic             meas_ge,
  output logic [4:0]       mode,
  output logic             duty_flag,
  output logic             irq_flag,
  output logic [CNT_W-1:0] per_a,
  output logic [CNT_W-1:0] high_a,
  output logic [CNT_W-1:0] per_b,
  output logic [CNT_W-1:0] high_b
);

  logic [4:0]       mode_q, mode_d;
  logic             flag_q, flag_d, irq_q, irq_d;
  logic [CNT_W-1:0] len_q [LEN_REGS];
  logic [CNT_W-1:0] len_d [LEN_REGS];
  logic             wr_mode, wr_stat;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_mode = wr && (addr == AW'(ADDR_MODE));
  assign wr_stat = wr && (addr == AW'(ADDR_STAT));

  always_comb begin
    // strobe bits 3:2 fall back to 0 on the cycle after they were written
    mode_d = {mode_q[4], 2'b00, mode_q[1:0]};
    if (wr_mode) mode_d = wdata[4:0];

    flag_d = flag_q;
    if (wr_stat)         flag_d = wdata[0];
    else if (meas_valid) flag_d = meas_ge;

    irq_d = irq_q;
    if (wr_stat && wdata[1]) irq_d = 1'b0;
    if (meas_valid)          irq_d = 1'b1;
  end

  for (genvar g = 0; g < LEN_REGS; g++) begin : g_len
    logic wr_hit;
    assign wr_hit = wr && (addr == AW'(ADDR_PER_A + g));
    always_comb len_d[g] = wr_hit ? wdata[CNT_W-1:0] : len_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q[g] <= '0;
      else        len_q[g] <= len_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADDR_MODE):  rdata = DW'(mode_q);
      AW'(ADDR_STAT):  rdata = DW'({irq_q, flag_q});
      AW'(ADDR_PER_A): rdata = DW'(len_q[0]);
      AW'(ADDR_HI_A):  rdata = DW'(len_q[1]);
      AW'(ADDR_PER_B): rdata = DW'(len_q[2]);
      AW'(ADDR_HI_B):  rdata = DW'(len_q[3]);
      default:         rdata = '0;
    endcase
  end

  assign mode      = mode_q;
  assign duty_flag = flag_q;
  assign irq_flag  = irq_q;
  assign per_a     = len_q[0];
  assign high_a    = len_q[1];
  assign per_b     = len_q[2];
  assign high_b    = len_q[3];

endmodule

// File: rtl/ctl_duty_unit.sv
module ctl_duty_unit
  import ctl_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DUTY_PCT    = 44
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          ctl_pb_in,
  output logic          ctl_rec_out,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);

  logic             rst_sync_n;
  logic             pb_rise, pb_fall;
  logic             meas_valid, meas_ge;
  logic [4:0]       mode_q;
  logic             duty_flag;
  logic [CNT_W-1:0] per_a, high_a, per_b, high_b;
  ctl_op_e          op_now, op_prev_q;
  logic             op_chg, det_en, rec_en;

  assign op_now = decode_op(mode_q);
  assign op_chg = op_now != op_prev_q;
  assign det_en = op_now == OP_DETECT;
  assign rec_en = op_now == OP_RECORD;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) op_prev_q <= OP_DETECT;
    else             op_prev_q <= op_now;
  end

  ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_sync_n)
  );

  ctl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (ctl_pb_in),
    .rise  (pb_rise),
    .fall  (pb_fall)
  );

  ctl_duty_meter #(.CNT_W(CNT_W), .DUTY_PCT(DUTY_PCT)) u_meter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (det_en),
    .restart    (op_chg),
    .rise       (pb_rise),
    .fall       (pb_fall),
    .meas_valid (meas_valid),
    .meas_ge    (meas_ge)
  );

  ctl_regs #(.CNT_W(CNT_W), .DW(DW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .meas_valid (meas_valid),
    .meas_ge    (meas_ge),
    .mode       (mode_q),
    .duty_flag  (duty_flag),
    .irq_flag   (irq),
    .per_a      (per_a),
    .high_a     (high_a),
    .per_b      (per_b),
    .high_b     (high_b)
  );

  ctl_rec_gen #(.CNT_W(CNT_W)) u_rec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (rec_en),
    .restart (op_chg),
    .sel_b   (duty_flag),
    .per_a   (per_a),
    .high_a  (high_a),
    .per_b   (per_b),
    .high_b  (high_b),
    .pulse   (ctl_rec_out)
  );

endmodule

// File: rtl/ctl_duty_unit_chk.sv
module ctl_duty_unit_chk #(
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          wdata_b0,
  input logic          wdata_b1,
  input logic          wdata_b3,
  input logic [4:0]    mode_q,
  input logic          irq,
  input logic          meas_valid,
  input logic          meas_ge,
  input logic          duty_flag,
  input logic          rec_out,
  input logic          rec_en
);

  logic wr_mode, wr_stat;
  logic unused_b0;
  assign unused_b0 = wdata_b0;
  assign wr_mode = reg_wr && (reg_addr == AW'(0));
  assign wr_stat = reg_wr && (reg_addr == AW'(1));

  // R8: strobe bit returns to 0 unless written again
  assert_strobe_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && !(wr_mode && wdata_b3)) |=> !mode_q[3]);

  // R4: interrupt holds until a clearing write
  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_stat && wdata_b1)) |=> irq);

  // R4: interrupt only appears after a completed measurement
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(meas_valid));

  // R2/R3: flag takes the verdict of the measurement
  assert_flag_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !wr_stat) |=> (duty_flag == $past(meas_ge)));

  // R9: record output quiet outside record mode
  assert_rec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> !rec_out);

endmodule

bind ctl_duty_unit ctl_duty_unit_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wdata_b0   (reg_wdata[0]),
  .wdata_b1   (reg_wdata[1]),
  .wdata_b3   (reg_wdata[3]),
  .mode_q     (mode_q),
  .irq        (irq),
  .meas_valid (meas_valid),
  .meas_ge    (meas_ge),
  .duty_flag  (duty_flag),
  .rec_out    (ctl_rec_out),
  .rec_en     (rec_en)
);

// File: tb/ctl_duty_unit_tb.sv
`timescale 1ns/1ps
module ctl_duty_unit_tb;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        pb;
  logic        rec_out;
  logic        wr;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ctl_duty_unit u_dut (
    .clk         (clk),
    .arst_n      (arst_n),
    .ctl_pb_in   (pb),
    .ctl_rec_out (rec_out),
    .reg_wr      (wr),
    .reg_addr    (addr),
    .reg_wdata   (wdata),
    .reg_rdata   (rdata),
    .irq         (irq)
  );

  // {high[7:0], low[7:0], expected flag}
  localparam logic [16:0] VEC [6] = '{
    {8'd11, 8'd14, 1'b1},   // exactly 44 %
    {8'd10, 8'd15, 1'b0},   // 40 %
    {8'd30, 8'd10, 1'b1},
    {8'd5,  8'd45, 1'b0},
    {8'd22, 8'd28, 1'b1},   // exactly 44 %
    {8'd21, 8'd29, 1'b0}    // 42 %
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse(input int h, input int l);
    pb = 1'b1;
    repeat (h) @(negedge clk);
    pb = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    while (rec_out !== 1'b0) @(negedge clk);
    while (rec_out !== 1'b1) @(negedge clk);
    hi = 0;
    while (rec_out === 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (rec_out === 1'b0) begin per++; @(negedge clk); end
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int hi, per, hi2, per2;
    pb = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    do_reset();

    // R1 reset state
    rreg(3'd0, v); chk("R1 mode", int'(v), 0);
    rreg(3'd1, v); chk("R1 status", int'(v), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rec_out", int'(rec_out), 0);

    // R2/R3/R4 vector table in detect mode
    for (int i = 0; i < 6; i++) begin
      int h, l, e;
      h = int'(VEC[i][16:9]);
      l = int'(VEC[i][8:1]);
      e = int'(VEC[i][0]);
      repeat (3) pulse(h, l);
      rreg(3'd1, v);
      if (e == 1) chk("R2 flag set", int'(v[0]), 1);
      else        chk("R3 flag clear", int'(v[0]), 0);
      chk("R4 irq per pulse", int'(irq), 1);
      wreg(3'd1, 16'h0002);
      @(negedge clk);
      chk("R4 irq cleared", int'(irq), 0);
    end

    // R4 first pulse after reset only arms
    do_reset();
    pulse(10, 10);
    repeat (4) @(negedge clk);
    chk("R4 first pulse no irq", int'(irq), 0);
    pulse(10, 10);
    chk("R4 second rise irq", int'(irq), 1);
    repeat (5) @(negedge clk);
    chk("R4 sticky", int'(irq), 1);
    wreg(3'd1, 16'h0002);

    // R8 strobe bits self-clear, mode unchanged
    wreg(3'd0, 16'h000C);
    @(negedge clk);
    rreg(3'd0, v); chk("R8 strobe cleared", int'(v), 0);
    repeat (2) pulse(12, 13);
    chk("R8 still detecting", int'(irq), 1);
    wreg(3'd1, 16'h0003);   // clear irq, flag = 1

    // R9 idle mode
    wreg(3'd0, 16'h0010);
    repeat (3) pulse(5, 45);
    rreg(3'd1, v);
    chk("R9 no irq", int'(v[1]), 0);
    chk("R9 flag kept", int'(v[0]), 1);
    chk("R9 rec low", int'(rec_out), 0);

    // R5 record with pair A
    wreg(3'd2, 16'd20);
    wreg(3'd3, 16'd5);
    wreg(3'd4, 16'd16);
    wreg(3'd5, 16'd12);
    wreg(3'd1, 16'h0000);
    wreg(3'd0, 16'h0001);
    measure(hi, per);
    measure(hi, per);
    chk("R5 high A", hi, 5);
    chk("R5 period A", per, 20);

    // R6 select pair B via flag
    wreg(3'd1, 16'h0001);
    measure(hi, per);
    chk("R6 high B", hi, 12);
    chk("R6 period B", per, 16);

    // R7 change during a period waits for boundary
    fork
      begin
        measure(hi, per);
        measure(hi2, per2);
      end
      begin
        while (rec_out !== 1'b0) @(negedge clk);
        while (rec_out !== 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
        wreg(3'd5, 16'd4);
        wreg(3'd4, 16'd10);
      end
    join
    chk("R7 running high kept", hi, 12);
    chk("R7 running period kept", per, 16);
    chk("R7 new high", hi2, 4);
    chk("R7 new period", per2, 10);

    // R9 leaving record silences output
    wreg(3'd0, 16'h0002);
    repeat (3) @(negedge clk);
    chk("R9 rec low after exit", int'(rec_out), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule